// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block connects a clocked request port to an external asynchronous static RAM with 17 address bits and a 16-bit data word split into two byte lanes. A user raises `req` for one cycle while the controller is idle. The request carries an address, a write flag, write data and a two-bit lane mask. The controller then drives the memory's active-low select, output-enable, write-enable and per-lane strobes. It returns a single-cycle `ack` when the operation has finished. For a read, the captured word is presented on `rd_data` in that same cycle.

A write is shaped as a window in which select, write-enable and at least one lane strobe are all low. The controller first lowers select and write-enable together with the address and data. The mask-selected strobes then fall for the pulse phase and rise again while address and data are still held; that rising edge closes the window. After a write, write-enable and select stay low while the controller idles. A following write therefore only pulses the strobes. A read that follows a write first raises write-enable for a turnaround phase before output-enable falls. The controller drives the data bus only during write phases, and it keeps output-enable high while it does so. The length of every phase is a parameter in clock cycles.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `sram_ce_n`, `sram_oe_n`, `sram_we_n`, `sram_ub_n` and `sram_lb_n` are 1, `dq_oe` is 0, `ack` is 0 and `rd_data` is 0.
- R2: A write changes only the lanes whose mask bit is 1. `req_mask[1]` selects bits 15..8 through `sram_ub_n`, and `req_mask[0]` selects bits 7..0 through `sram_lb_n`. A mask of 00 changes nothing.
- R3: A read returns the stored byte in each lane whose mask bit is 1 and returns 0 in the other lanes, whatever the bus carries there. `rd_data` changes only in the cycle in which a read's `ack` rises.
- R4: Each accepted request yields exactly one `ack`, and `ack` is high for one cycle. A `req` raised while an operation is in progress is ignored.
- R5: `dq_oe` is 1 only while `sram_oe_n` is 1, so the controller and the memory never drive the bus at the same time.
- R6: A strobe falls during a write only after at least one cycle in which `sram_we_n` and `sram_ce_n` were low and the data was already driven. Address and data remain stable throughout the pulse and for the cycle after the strobe rises.
- R7: After a write completes and while no request is pending, `sram_we_n` and `sram_ce_n` stay low, with the strobes and `sram_oe_n` high. Consecutive writes do not toggle `sram_we_n`.
- R8: `sram_oe_n` and `sram_we_n` are never low together. When `sram_oe_n` falls, `sram_we_n` has already been high for at least one cycle.
- R9: With default parameters, `ack` comes 3 cycles after the accepting edge for a write. For a read it comes 2 cycles after that edge if the last operation was a read or nothing, and 3 cycles after if the last operation was a write.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, sampled only when idle |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 1 upper byte, bit 0 lower byte |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read word |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_ub_n | output | 1 | Upper lane strobe, active low |
| sram_lb_n | output | 1 | Lower lane strobe, active low |
| sram_addr | output | 17 | Memory address |
| dq_out | output | 16 | Data driven toward the memory |
| dq_in | input | 16 | Data returned from the memory |
| dq_oe | output | 1 | 1 while the controller drives the bus |

## Verification
Two things can coincide in one cycle. One is the acceptance decision in the idle state. The other is an incoming request that arrives while a write is still in flight, and this second request must be dropped. The bench provokes this by raising a second write request to a different address in the cycle right after an accepted write. It judges the outcome in two ways: exactly one acknowledge must arrive, and a later read must show the second address untouched. The other overlap is a read that lands on a controller still holding write-enable low after a write. This is judged by the longer read latency, and by checking that output-enable never falls while write-enable is low.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    localparam int LANE_W = 8;
    localparam int NUM_LANES = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_TURN = 3'd1,
        ST_WSET = 3'd2,
        ST_WPUL = 3'd3,
        ST_WEND = 3'd4,
        ST_RACC = 3'd5,
        ST_RGAP = 3'd6
    } seq_st_t;

    typedef struct packed {
        logic                 ce_n;
        logic                 oe_n;
        logic                 we_n;
        logic [NUM_LANES-1:0] stb_n;
        logic                 drive;
    } pin_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels that belong to each sequencer state.
    function automatic pin_t pins_for(input seq_st_t st, input logic wopen,
                                      input logic [NUM_LANES-1:0] mask);
        pin_t p;
        p.ce_n  = 1'b1;
        p.oe_n  = 1'b1;
        p.we_n  = 1'b1;
        p.stb_n = '1;
        p.drive = 1'b0;
        case (st)
            ST_IDLE: begin
                p.ce_n = ~wopen;
                p.we_n = ~wopen;
            end
            ST_TURN: p.ce_n = 1'b0;
            ST_WSET, ST_WEND: begin
                p.ce_n  = 1'b0;
                p.we_n  = 1'b0;
                p.drive = 1'b1;
            end
            ST_WPUL: begin
                p.ce_n  = 1'b0;
                p.we_n  = 1'b0;
                p.drive = 1'b1;
                p.stb_n = ~mask;
            end
            ST_RACC: begin
                p.ce_n  = 1'b0;
                p.oe_n  = 1'b0;
                p.stb_n = ~mask;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sramc_capture.sv
module sramc_capture
    import sramc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap_en,
    input  logic [NUM_LANES-1:0] cap_mask,
    input  logic [DATA_W-1:0]    dq_in,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_data[g*LANE_W +: LANE_W] <= '0;
            end else if (cap_en) begin
                rd_data[g*LANE_W +: LANE_W] <= cap_mask[g] ? dq_in[g*LANE_W +: LANE_W]
                                                           : '0;
            end
        end
    end

    AST_CAP_STABLE: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(rd_data)); // R3

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1,
    parameter int TURN_CYC  = 1,
    parameter int RD_CYC    = 2,
    parameter int GAP_CYC   = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 req_wr,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [NUM_LANES-1:0] req_mask,
    output logic                 ack,
    output logic                 cap_en,
    output logic [NUM_LANES-1:0] cap_mask,
    output logic                 ce_n,
    output logic                 oe_n,
    output logic                 we_n,
    output logic [NUM_LANES-1:0] stb_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    dq_out,
    output logic                 dq_oe
);
    localparam int LONGEST = imax(imax(imax(SETUP_CYC, PULSE_CYC), imax(HOLD_CYC, TURN_CYC)),
                                  imax(RD_CYC, GAP_CYC));
    localparam int CNT_W = (LONGEST > 1) ? $clog2(LONGEST) : 1;
    localparam logic [CNT_W-1:0] LAST_SET  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_PUL  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_HOLD = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_TURN = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_RD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_GAP  = CNT_W'(GAP_CYC - 1);

    seq_st_t              st, st_nx;
    logic [CNT_W-1:0]     cnt;
    logic                 last;
    logic                 wopen, wopen_nx;
    logic                 accept;
    logic [NUM_LANES-1:0] c_mask;
    logic [ADDR_W-1:0]    c_addr;
    logic [DATA_W-1:0]    c_wdata;
    logic [NUM_LANES-1:0] mask_nx;
    pin_t                 pins_nx;

    always_comb begin
        case (st)
            ST_TURN: last = (cnt == LAST_TURN);
            ST_WSET: last = (cnt == LAST_SET);
            ST_WPUL: last = (cnt == LAST_PUL);
            ST_WEND: last = (cnt == LAST_HOLD);
            ST_RACC: last = (cnt == LAST_RD);
            ST_RGAP: last = (cnt == LAST_GAP);
            default: last = 1'b1;
        endcase
    end

    always_comb begin
        st_nx    = st;
        wopen_nx = wopen;
        accept   = 1'b0;
        case (st)
            ST_IDLE: if (req) begin
                accept = 1'b1;
                if (req_wr) begin
                    st_nx = ST_WSET;
                end else if (wopen) begin
                    st_nx    = ST_TURN;
                    wopen_nx = 1'b0;
                end else begin
                    st_nx = ST_RACC;
                end
            end
            ST_TURN: if (last) st_nx = ST_RACC;
            ST_WSET: if (last) st_nx = ST_WPUL;
            ST_WPUL: if (last) st_nx = ST_WEND;
            ST_WEND: if (last) begin
                st_nx    = ST_IDLE;
                wopen_nx = 1'b1;
            end
            ST_RACC: if (last) st_nx = ST_RGAP;
            ST_RGAP: if (last) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    assign mask_nx = accept ? req_mask : c_mask;
    assign pins_nx = pins_for(st_nx, wopen_nx, mask_nx);
    assign cap_en  = (st == ST_RACC) && last;
    assign cap_mask = c_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            wopen   <= 1'b0;
            c_mask  <= '0;
            c_addr  <= '0;
            c_wdata <= '0;
            ack     <= 1'b0;
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            stb_n   <= '1;
            dq_oe   <= 1'b0;
            mem_addr <= '0;
            dq_out  <= '0;
        end else begin
            st    <= st_nx;
            wopen <= wopen_nx;
            if (st_nx != st || st == ST_IDLE) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (accept) begin
                c_mask  <= req_mask;
                c_addr  <= req_addr;
                c_wdata <= req_wdata;
            end
            ack      <= ((st == ST_WEND) || (st == ST_RACC)) && last;
            ce_n     <= pins_nx.ce_n;
            oe_n     <= pins_nx.oe_n;
            we_n     <= pins_nx.we_n;
            stb_n    <= pins_nx.stb_n;
            dq_oe    <= pins_nx.drive;
            mem_addr <= accept ? req_addr : c_addr;
            dq_out   <= accept ? req_wdata : c_wdata;
        end
    end

    AST_NO_CONTEND: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> oe_n); // R5

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R4

    AST_OE_NEEDS_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |-> (we_n && $past(we_n))); // R8

    AST_STB_SETUP: assert property (@(posedge clk) disable iff (rst)
        (($fell(stb_n[0]) || $fell(stb_n[1])) && !we_n)
        |-> $past(!we_n && !ce_n && dq_oe)); // R6

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!we_n && stb_n != '1) |=> ($stable(mem_addr) && $stable(dq_out) && dq_oe)); // R6

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1,
    parameter int TURN_CYC  = 1,
    parameter int RD_CYC    = 2,
    parameter int GAP_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] dq_out,
    input  logic [DATA_W-1:0] dq_in,
    output logic              dq_oe
);
    logic                 cap_en;
    logic [NUM_LANES-1:0] cap_mask;
    logic [NUM_LANES-1:0] stb_n;

    sramc_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC),
        .TURN_CYC(TURN_CYC), .RD_CYC(RD_CYC), .GAP_CYC(GAP_CYC)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask),
        .ack(ack), .cap_en(cap_en), .cap_mask(cap_mask),
        .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n), .stb_n(stb_n),
        .mem_addr(sram_addr), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    sramc_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst),
        .cap_en(cap_en), .cap_mask(cap_mask),
        .dq_in(dq_in), .rd_data(rd_data)
    );

    assign sram_ub_n = stb_n[1];
    assign sram_lb_n = stb_n[0];

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
    localparam int AW = 17;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          req = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          ack, ce_n, oe_n, we_n, ub_n, lb_n, dq_oe;
    logic [DW-1:0] rd_data, dq_out;
    logic [DW-1:0] dq_in = '0;
    logic [AW-1:0] sram_addr;

    sram_async_ctrl i_sram_async_ctrl (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .ack(ack), .rd_data(rd_data),
        .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n), .sram_ub_n(ub_n),
        .sram_lb_n(lb_n), .sram_addr(sram_addr), .dq_out(dq_out), .dq_in(dq_in),
        .dq_oe(dq_oe)
    );

    int total = 0, bad = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mem [int unsigned];
    bit [1:0]    prev_act = '0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_data = '0;
    bit          prev_we = 1'b1, prev_ce = 1'b1, prev_oe_drv = 1'b0;
    int          contend = 0, r6_bad = 0, r8_bad = 0, we_rises = 0;

    always @(negedge clk) begin
        bit [1:0] act;
        logic [15:0] cur;
        act[1] = !ce_n && !we_n && !ub_n;
        act[0] = !ce_n && !we_n && !lb_n;
        if (!rst) begin
            if (dq_oe && !oe_n) contend++;
            if (!oe_n && !we_n) r8_bad++;
            if (!prev_we && we_n) we_rises++;
            for (int i = 0; i < 2; i++) begin
                if (act[i] && !prev_act[i] && !(!prev_we && !prev_ce && prev_oe_drv)) r6_bad++;
                if (act[i] && !dq_oe) r6_bad++;
                if (act[i] && prev_act[i] && (sram_addr != prev_addr || dq_out != prev_data)) r6_bad++;
                if (!act[i] && prev_act[i]) begin
                    if (sram_addr != prev_addr || dq_out != prev_data || !dq_oe) r6_bad++;
                    cur = mem.exists(int'(prev_addr)) ? mem[int'(prev_addr)] : 16'h0;
                    cur[i*8 +: 8] = prev_data[i*8 +: 8];
                    mem[int'(prev_addr)] = cur;
                end
            end
        end
        prev_act    = act;
        prev_addr   = sram_addr;
        prev_data   = dq_out;
        prev_we     = we_n;
        prev_ce     = ce_n;
        prev_oe_drv = dq_oe;
        cur = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 16'h0;
        // unselected lanes carry junk so that lane gating is visible
        dq_in[15:8] <= (!ce_n && !oe_n && we_n && !ub_n) ? cur[15:8] : 8'hEE;
        dq_in[7:0]  <= (!ce_n && !oe_n && we_n && !lb_n) ? cur[7:0]  : 8'hEE;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          rd;
        logic [15:0] data;
        int          lat;
        string       tag;
    } item_t;
    item_t       q[$];
    longint      req_cyc = 0;
    logic [15:0] shadow [int unsigned];
    bit          last_wr = 1'b0;

    always @(negedge clk) begin
        if (!rst && ack) begin
            if (q.size() == 0) begin
                chk(1'b0, "R4 spurious ack", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(int'(cyc - req_cyc - 1) == it.lat, "R9 latency",
                    32'(cyc - req_cyc - 1), 32'(it.lat));
                if (it.rd) chk(rd_data == it.data, it.tag, 32'(rd_data), 32'(it.data));
            end
        end
    end

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                         input logic [1:0] m, input string tag, input bit inject,
                         input logic [AW-1:0] ia);
        item_t it;
        logic [15:0] sh;
        sh = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        it.rd  = !wr;
        it.tag = tag;
        it.lat = (wr || last_wr) ? 3 : 2;
        it.data = {m[1] ? sh[15:8] : 8'h00, m[0] ? sh[7:0] : 8'h00};
        if (wr) begin
            if (m[1]) sh[15:8] = d[15:8];
            if (m[0]) sh[7:0]  = d[7:0];
            shadow[int'(a)] = sh;
        end
        last_wr = wr;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
        req_cyc = cyc;
        q.push_back(it);
        @(negedge clk);
        if (inject) begin
            req_wr = 1'b1; req_addr = ia; req_wdata = 16'h2222; req_mask = 2'b11;
        end else begin
            req = 1'b0;
        end
        @(negedge clk);
        req = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_all();
        int rises;
        repeat (3) @(negedge clk);
        // R1: during reset
        chk({ce_n, oe_n, we_n, ub_n, lb_n, dq_oe, ack} == 7'b1111100, "R1 pins in reset",
            32'({ce_n, oe_n, we_n, ub_n, lb_n, dq_oe, ack}), 32'h7C);
        rst = 1'b0;
        @(negedge clk);
        chk({ce_n, oe_n, we_n, ub_n, lb_n, dq_oe, ack} == 7'b1111100, "R1 pins after reset",
            32'({ce_n, oe_n, we_n, ub_n, lb_n, dq_oe, ack}), 32'h7C);
        chk(rd_data == 16'h0, "R1 rd_data", 32'(rd_data), 32'h0);

        // R2 word write then R8 read from write-open state, then plain read
        do_op(1, 17'h00010, 16'h1234, 2'b11, "R2 word", 0, '0);
        chk(!we_n && !ce_n && ub_n && lb_n && oe_n && !dq_oe, "R7 idle after write",
            32'({we_n, ce_n, ub_n, lb_n, oe_n, dq_oe}), 32'b001110);
        do_op(0, 17'h00010, 16'h0, 2'b11, "R8 read after write", 0, '0);
        do_op(0, 17'h00010, 16'h0, 2'b11, "R9 read after read", 0, '0);

        // R7 burst of lane writes without we_n toggling
        rises = we_rises;
        do_op(1, 17'h00021, 16'hABCD, 2'b01, "R2 lower lane", 0, '0);
        do_op(1, 17'h00021, 16'h5599, 2'b10, "R2 upper lane", 0, '0);
        do_op(1, 17'h00022, 16'hBEEF, 2'b11, "R7 third write", 0, '0);
        chk(we_rises == rises + 0 || we_rises == rises, "R7 we_n held low",
            32'(we_rises), 32'(rises));

        // R3 lane masking on reads
        do_op(0, 17'h00021, 16'h0, 2'b11, "R2 merged lanes", 0, '0);
        do_op(0, 17'h00021, 16'h0, 2'b10, "R3 upper only", 0, '0);
        do_op(0, 17'h00021, 16'h0, 2'b01, "R3 lower only", 0, '0);
        do_op(0, 17'h00021, 16'h0, 2'b00, "R3 no lanes", 0, '0);
        do_op(0, 17'h00022, 16'h0, 2'b11, "R7 burst word", 0, '0);

        // R2 empty mask writes nothing
        do_op(1, 17'h00030, 16'hFFFF, 2'b00, "R2 empty mask", 0, '0);
        do_op(0, 17'h00030, 16'h0, 2'b11, "R2 empty mask read", 0, '0);

        // R4 request during busy write is dropped
        do_op(1, 17'h00040, 16'h1111, 2'b11, "R4 accepted write", 1, 17'h00041);
        do_op(0, 17'h00041, 16'h0, 2'b11, "R4 ignored write", 0, '0);
        do_op(0, 17'h00040, 16'h0, 2'b11, "R4 kept write", 0, '0);

        // R2 top address boundary
        do_op(1, 17'h1FFFF, 16'hC35A, 2'b11, "R2 top addr", 0, '0);
        do_op(0, 17'h1FFFF, 16'h0, 2'b11, "R2 top addr read", 0, '0);
        do_op(0, 17'h00000, 16'h0, 2'b11, "R2 zero addr read", 0, '0);

        chk(contend == 0, "R5 bus contention", 32'(contend), 32'h0);
        chk(r6_bad == 0, "R6 write window", 32'(r6_bad), 32'h0);
        chk(r8_bad == 0, "R8 oe with we", 32'(r8_bad), 32'h0);
    endtask

    bit wd = 1'b0;
    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) chk(1'b0, "watchdog", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule